// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider with Lock Qualifier

This block holds the digital counting chain of a frequency synthesizer loop. One counter divides a reference tick stream down to the comparison rate and emits a one-cycle reference strobe. A second pair of counters divides the output of an external dual-modulus prescaler, which divides by 64 or 65. The block steers that prescaler through a modulus-select output, so the whole feedback path divides the oscillator by 64·N + A and emits a one-cycle feedback strobe.

A third piece watches the two strobes. When they keep arriving close together it raises a lock flag. The flag needs four good comparisons in a row, and a single bad one drops it. Divider settings arrive on parallel inputs and are captured on a load strobe. Each counter switches to its new setting only when it next wraps, so a period that is already running is never cut short. All logic runs on one system clock. The reference input and the prescaler output reach the block as one-cycle enables.

Top module: `pulse_swallow_divider`

## Requirements
- R1: After a synchronous active-low reset, fr_pulse, fv_pulse, lock and cfg_err are 0, and mod_sel is 0, because the reset setting is A = 0.
- R2: fr_pulse fires for one clock after every R-th ref_ce, where R is the 14-bit divider setting. A setting of 0 behaves as 1. With ref_ce held high, the spacing between strobes is R clocks.
- R3: fv_pulse fires for one clock on the N-th psc_ce, where N is the 10-bit setting and 0 behaves as 1. With a prescaler that follows mod_sel, the spacing is 64·N + A oscillator cycles.
- R4: mod_sel is 1 (divide by 65) for the first A prescaler cycles of each feedback period and 0 (divide by 64) for the rest. It changes only on the clock after a psc_ce, so over one feedback period it is high for 65·A oscillator cycles.
- R5: When the 7-bit setting A is greater than the effective N, mod_sel stays 0 for the whole period, the period becomes 64·N, and cfg_err reads 1.
- R6: A setting captured by cfg_load takes effect at the next wrap of the counter it belongs to. The period already running keeps the old length.
- R7: lock rises only after four consecutive comparisons in which the second strobe of a pair arrives within cfg_win ref_ce ticks of the first. After three such comparisons it is still 0.
- R8: A single comparison in which the other strobe does not arrive within cfg_win ticks clears lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_ce | input | 1 | One-cycle enable per reference cycle |
| psc_ce | input | 1 | One-cycle enable per prescaler output cycle |
| cfg_r | input | 14 | Reference divider setting |
| cfg_n | input | 10 | Feedback main-count setting |
| cfg_a | input | 7 | Swallow-count setting |
| cfg_win | input | 8 | Lock window in ref_ce ticks |
| cfg_load | input | 1 | Captures cfg_r, cfg_n and cfg_a |
| mod_sel | output | 1 | 1 asks the prescaler for divide by 65, 0 for divide by 64 |
| fr_pulse | output | 1 | Divided reference strobe |
| fv_pulse | output | 1 | Divided feedback strobe |
| lock | output | 1 | Lock qualified flag |
| cfg_err | output | 1 | Swallow count larger than main count |

## Verification
The bench models the prescaler and the reference directly. It targets the period edges: A equal to N, where every cycle must be a divide-by-65 cycle (a wrong compare would drop one and give 64·N + A − 1), A greater than N (a design that swallows anyway would produce an irregular period and no error), zero settings that must behave as 1, and the largest R. It loads a setting just after a wrap and measures the period still running, which exposes a design that reloads immediately. For lock, it samples between the third and fourth good comparison to catch an off-by-one streak count. It then detunes N by one step to confirm that a single late strobe drops lock.

// File: rtl/synth_div_pkg.sv
// Shared widths, reset settings and state encoding for the divider chain.
package synth_div_pkg;
    localparam int R_W      = 14;    // reference divider width
    localparam int N_W      = 10;    // feedback main counter width
    localparam int A_W      = 7;     // swallow counter width
    localparam int WIN_W    = 8;     // lock window width
    localparam int LOCK_RUNS = 4;    // good comparisons needed for lock
    localparam int R_RESET  = 2560;  // 12.8 MHz / 5 kHz
    localparam int N_RESET  = 40;    // 64*40 + 0 = 2560
    localparam int A_RESET  = 0;

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_WAIT_V = 2'd1,
        LD_WAIT_R = 2'd2
    } ld_state_t;
endpackage

// File: rtl/ref_divider.sv
// Divides a tick stream by a programmable count and emits a one-cycle strobe
// on the wrap. Assumes div is stable between loads; div = 0 acts as 1.
// The new div is picked up only when the counter wraps.
module ref_divider #(
    parameter int W   = 14,
    parameter int DEF = 2560
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] div,
    output logic         pulse
);
    logic [W-1:0] cnt;
    logic [W-1:0] reload_val;

    // Next start value; a zero setting degrades to divide-by-one.
    always_comb begin
        reload_val = (div == '0) ? '0 : div - 1'b1;
    end

    // Down-counter with wrap strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= W'(DEF - 1);
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt == '0) begin
                    cnt   <= reload_val;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/swallow_ctrl.sv
// Main and swallow counters for a 64/65 prescaler. Counts prescaler output
// ticks: the first A ticks of each period request divide-by-65, the rest
// divide-by-64. Both counters reload together when the main count wraps.
// Assumes the prescaler samples mod_hi at the start of each of its cycles.
module swallow_ctrl #(
    parameter int N_W   = 10,
    parameter int A_W   = 7,
    parameter int N_DEF = 40,
    parameter int A_DEF = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           psc_tick,
    input  logic [N_W-1:0] n_div,
    input  logic [A_W-1:0] a_div,
    output logic           mod_hi,
    output logic           fv,
    output logic           illegal
);
    localparam int CMP_W = (N_W > A_W) ? N_W : A_W;
    localparam logic DEF_BAD = (A_DEF > N_DEF);

    logic [N_W-1:0] n_cnt;
    logic [A_W-1:0] a_rem;
    logic [N_W-1:0] n_eff;
    logic           legal;

    // Effective main count and legality of the pending setting.
    always_comb begin
        n_eff = (n_div == '0) ? N_W'(1) : n_div;
        legal = (CMP_W'(a_div) <= CMP_W'(n_eff));
    end

    // Request divide-by-65 while swallow cycles remain.
    always_comb begin
        mod_hi = (a_rem != '0);
    end

    // Main counter, swallow counter and error flag, all advanced per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cnt   <= N_W'(N_DEF - 1);
            a_rem   <= DEF_BAD ? '0 : A_W'(A_DEF);
            illegal <= DEF_BAD;
            fv      <= 1'b0;
        end else begin
            fv <= 1'b0;
            if (psc_tick) begin
                if (n_cnt == '0) begin
                    n_cnt   <= n_eff - 1'b1;
                    a_rem   <= legal ? a_div : '0;
                    illegal <= !legal;
                    fv      <= 1'b1;
                end else begin
                    n_cnt <= n_cnt - 1'b1;
                    if (a_rem != '0) begin
                        a_rem <= a_rem - 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lock_window.sv
// Pairs reference and feedback strobes. After one strobe, the other must
// follow within win ticks of the reference enable. RUNS good pairs in a
// row set locked; one bad pair clears it. A repeated strobe of the same
// kind before its partner counts as a bad pair.
module lock_window
    import synth_div_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int RUNS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fr,
    input  logic             fv,
    input  logic [WIN_W-1:0] win,
    output logic             locked
);
    localparam int STR_W = $clog2(RUNS + 1);

    ld_state_t        st, st_n;
    logic [WIN_W-1:0] gap, gap_n;
    logic [STR_W-1:0] streak;
    logic             good, bad;

    // Pairing state machine: decides good or bad comparisons.
    always_comb begin
        good  = 1'b0;
        bad   = 1'b0;
        st_n  = st;
        gap_n = gap;
        case (st)
            LD_IDLE: begin
                if (fr && fv) begin
                    good = 1'b1;
                end else if (fr) begin
                    st_n  = LD_WAIT_V;
                    gap_n = '0;
                end else if (fv) begin
                    st_n  = LD_WAIT_R;
                    gap_n = '0;
                end
            end
            LD_WAIT_V: begin
                if (fv) begin
                    good = 1'b1;
                    st_n = LD_IDLE;
                end else if (fr) begin
                    bad   = 1'b1;
                    gap_n = '0;
                end else if (tick) begin
                    if (gap == win) begin
                        bad  = 1'b1;
                        st_n = LD_IDLE;
                    end else begin
                        gap_n = gap + 1'b1;
                    end
                end
            end
            LD_WAIT_R: begin
                if (fr) begin
                    good = 1'b1;
                    st_n = LD_IDLE;
                end else if (fv) begin
                    bad   = 1'b1;
                    gap_n = '0;
                end else if (tick) begin
                    if (gap == win) begin
                        bad  = 1'b1;
                        st_n = LD_IDLE;
                    end else begin
                        gap_n = gap + 1'b1;
                    end
                end
            end
            default: st_n = LD_IDLE;
        endcase
    end

    // State and window counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= LD_IDLE;
            gap <= '0;
        end else begin
            st  <= st_n;
            gap <= gap_n;
        end
    end

    // Saturating run counter and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak <= '0;
            locked <= 1'b0;
        end else if (bad) begin
            streak <= '0;
            locked <= 1'b0;
        end else if (good) begin
            if (streak != STR_W'(RUNS)) begin
                streak <= streak + 1'b1;
            end
            locked <= (streak >= STR_W'(RUNS - 1));
        end
    end
endmodule

// File: rtl/pulse_swallow_divider.sv
// Top of the divider chain: captures divider settings on cfg_load and
// feeds them to the reference divider, the swallow controller and the
// lock qualifier. One clock domain; reference and prescaler activity
// arrive as single-cycle enables.
module pulse_swallow_divider
    import synth_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_ce,
    input  logic             psc_ce,
    input  logic [R_W-1:0]   cfg_r,
    input  logic [N_W-1:0]   cfg_n,
    input  logic [A_W-1:0]   cfg_a,
    input  logic [WIN_W-1:0] cfg_win,
    input  logic             cfg_load,
    output logic             mod_sel,
    output logic             fr_pulse,
    output logic             fv_pulse,
    output logic             lock,
    output logic             cfg_err
);
    logic [R_W-1:0] r_hold;
    logic [N_W-1:0] n_hold;
    logic [A_W-1:0] a_hold;

    // Setting capture; counters consume it at their own next wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_hold <= R_W'(R_RESET);
            n_hold <= N_W'(N_RESET);
            a_hold <= A_W'(A_RESET);
        end else if (cfg_load) begin
            r_hold <= cfg_r;
            n_hold <= cfg_n;
            a_hold <= cfg_a;
        end
    end

    ref_divider #(
        .W   (R_W),
        .DEF (R_RESET)
    ) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_ce),
        .div   (r_hold),
        .pulse (fr_pulse)
    );

    swallow_ctrl #(
        .N_W   (N_W),
        .A_W   (A_W),
        .N_DEF (N_RESET),
        .A_DEF (A_RESET)
    ) u_swl (
        .clk      (clk),
        .rst_n    (rst_n),
        .psc_tick (psc_ce),
        .n_div    (n_hold),
        .a_div    (a_hold),
        .mod_hi   (mod_sel),
        .fv       (fv_pulse),
        .illegal  (cfg_err)
    );

    lock_window #(
        .WIN_W (WIN_W),
        .RUNS  (LOCK_RUNS)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ref_ce),
        .fr     (fr_pulse),
        .fv     (fv_pulse),
        .win    (cfg_win),
        .locked (lock)
    );
endmodule

// File: rtl/divider_checker.sv
// Temporal checks on the divider chain ports, bound into the top module.
module divider_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_ce,
    input logic psc_ce,
    input logic mod_sel,
    input logic fr_pulse,
    input logic fv_pulse,
    input logic lock,
    input logic cfg_err
);
    // R2: a reference strobe follows a reference enable.
    p_fr_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fr_pulse |-> $past(ref_ce));

    // R3: a feedback strobe follows a prescaler enable.
    p_fv_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fv_pulse |-> $past(psc_ce));

    // R4: modulus select moves only after a prescaler enable.
    p_modsel_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(psc_ce) |-> $stable(mod_sel));

    // R5: an illegal swallow count never asks for divide-by-65.
    p_err_div64_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !mod_sel);

    // R7: lock can only rise right after a strobe completes a pair.
    p_lock_on_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(fr_pulse || fv_pulse));
endmodule

bind pulse_swallow_divider divider_checker u_chk (.*);

// File: tb/sim_pulse_swallow_divider.sv
module sim_pulse_swallow_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_ce = 1'b0;
    logic        psc_ce = 1'b0;
    logic [13:0] cfg_r = 14'd2560;
    logic [9:0]  cfg_n = 10'd40;
    logic [6:0]  cfg_a = 7'd0;
    logic [7:0]  cfg_win = 8'd8;
    logic        cfg_load = 1'b0;
    logic        mod_sel, fr_pulse, fv_pulse, lock, cfg_err;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // Columns: R, N, A, expected Fr period, expected Fv period, expected error.
    localparam int NV = 7;
    localparam int VEC [NV][6] = '{
        '{  643, 10, 3,   643, 643, 0},
        '{ 2560, 40, 0,  2560, 2560, 0},
        '{  200,  3, 3,   200, 195, 0},
        '{    1,  1, 1,     1,  65, 0},
        '{    0,  0, 0,     1,  64, 0},
        '{16383,  1, 0, 16383,  64, 0},
        '{  100,  2, 5,   100, 128, 1}
    };

    pulse_swallow_divider u0 (
        .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .psc_ce(psc_ce),
        .cfg_r(cfg_r), .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_win(cfg_win),
        .cfg_load(cfg_load), .mod_sel(mod_sel), .fr_pulse(fr_pulse),
        .fv_pulse(fv_pulse), .lock(lock), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                finish_run();
            end
        end
    end

    // Behavioural 64/65 prescaler: the oscillator advances one cycle per clock.
    initial begin
        int pc = 0;
        int m = 64;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pc = 0;
                psc_ce = 1'b0;
            end else begin
                if (pc == 0) m = mod_sel ? 65 : 64;
                pc++;
                psc_ce = (pc == m);
                if (psc_ce) pc = 0;
            end
        end
    end

    task automatic wait_clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_fv();
        do @(negedge clk); while (!fv_pulse);
    endtask

    task automatic wait_fr();
        do @(negedge clk); while (!fr_pulse);
    endtask

    // Clocks to the next fv strobe, plus clocks with mod_sel high on the way.
    task automatic measure_fv(output int per, output int hi);
        per = 0;
        hi = 0;
        do begin
            @(negedge clk);
            per++;
            if (mod_sel) hi++;
        end while (!fv_pulse);
    endtask

    task automatic measure_fr(output int per);
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!fr_pulse);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_ce = 1'b1;
        wait_clocks(3);
        rst_n = 1'b1;
    endtask

    initial begin
        int per, hi, prev_fv;
        // R1: reset state.
        ref_ce = 1'b1;
        wait_clocks(3);
        chk("R1 fr_pulse", fr_pulse, 0);
        chk("R1 fv_pulse", fv_pulse, 0);
        chk("R1 lock", lock, 0);
        chk("R1 cfg_err", cfg_err, 0);
        chk("R1 mod_sel", mod_sel, 0);
        rst_n = 1'b1;

        // R7: reset settings match (2560 both sides); four pairs are needed.
        wait_clocks(3 * 2560 + 300);
        chk("R7 lock after three pairs", lock, 0);
        wait_clocks(2560);
        chk("R7 lock after four pairs", lock, 1);

        // R8: detune N by one step; the first late strobe clears lock.
        wait_fv();
        cfg_n = 10'd41;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        wait_clocks(3 * 2624);
        chk("R8 lock cleared", lock, 0);
        prev_fv = 2624;

        // Vector walk: R6 old period, R3 new period, R4 swallow time,
        // R5 error flag, R2 reference period.
        for (int i = 0; i < NV; i++) begin
            wait_fv();
            cfg_r = 14'(VEC[i][0]);
            cfg_n = 10'(VEC[i][1]);
            cfg_a = 7'(VEC[i][2]);
            cfg_load = 1'b1;
            measure_fv(per, hi);
            cfg_load = 1'b0;
            chk($sformatf("R6 running period kept v%0d", i), per, prev_fv);
            measure_fv(per, hi);
            chk($sformatf("R3 fv period v%0d", i), per, VEC[i][4]);
            chk($sformatf("R4 divide-by-65 clocks v%0d", i), hi,
                VEC[i][5] ? 0 : 65 * VEC[i][2]);
            chk($sformatf("R5 cfg_err v%0d", i), cfg_err, VEC[i][5]);
            wait_fr();
            measure_fr(per);
            chk($sformatf("R2 fr period v%0d", i), per, VEC[i][3]);
            prev_fv = VEC[i][4];
        end

        // R1: reset clears the error left by the last (illegal) vector.
        do_reset();
        @(negedge clk);
        chk("R1 cfg_err after reset", cfg_err, 0);
        chk("R1 lock after reset", lock, 0);
        chk("R1 mod_sel after reset", mod_sel, 0);

        finish_run();
    end
endmodule